// File: doc/BRIEF.md
# Byte-Paired Register Access Interface

This block is the host-facing register front end of a data converter whose bus is only eight bits wide. The host writes 16-bit words as two byte transfers, low half first. When the second byte lands, the two top bits of the assembled word pick a destination and the other fourteen bits are stored there. The destination is either the internal control register or a write port into the calibration store. The remaining address codes reach no writable register.

Reads carry no address. A two-bit read-select field inside the control register decides which 16-bit source a read returns: the conversion result, the status word, the calibration store, or zero. That choice stays in force until the control register is written again. A high-byte-enable input picks which half of the selected word appears on the 8-bit read bus. All strobes are sampled on the block clock. Each strobe is acted on once, on the cycle it first asserts while chip select is high.

Top module: `byte_pair_regif`

## Requirements
- R1: While reset is held and immediately after it, `ctrl` is 0, `rd_byte` is 0 and `cal_wr_en` is 0. The next write byte is treated as the low half.
- R2: A word is formed from two byte writes. The first byte gives word bits 7:0 and the second gives bits 15:8. No destination changes after only the first byte.
- R3: A completed word whose bits 15:14 are 2'b11 loads its bits 13:0 into `ctrl` at the clock edge that accepts the second byte.
- R4: A completed word whose bits 15:14 are 2'b10 raises `cal_wr_en` for exactly one cycle, with bits 13:0 on `cal_wr_data`, in the cycle after the second byte is accepted.
- R5: A completed word whose bits 15:14 are 2'b00 or 2'b01 leaves `ctrl` unchanged and does not raise `cal_wr_en`.
- R6: The read source is chosen by `ctrl` bits 7:6: 2'b00 gives `conv_data`, 2'b01 gives zero, 2'b10 gives `cal_rd_data` and 2'b11 gives `status_in`. This choice holds for every read until the next control write.
- R7: A read with `hi_byte`=1 returns bits 15:8 of the selected source, and with `hi_byte`=0 returns bits 7:0. `rd_byte` is registered at the accepting edge and holds until the next accepted read.
- R8: A strobe held high for several cycles counts as a single transfer.
- R9: Strobes asserted while `cs` is low are ignored.
- R10: `cal_rd_adv` pulses for one cycle after an accepted high-byte read while read-select is 2'b10, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| wr_stb | input | 1 | Write strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| hi_byte | input | 1 | Selects the upper half of the read word |
| wr_byte | input | 8 | Write data byte |
| rd_byte | output | 8 | Registered read data byte |
| conv_data | input | 16 | Conversion result word |
| status_in | input | 16 | Status word |
| cal_rd_data | input | 16 | Word currently presented by the calibration store |
| ctrl | output | 14 | Control register contents |
| cal_wr_en | output | 1 | One-cycle calibration write pulse |
| cal_wr_data | output | 14 | Calibration write payload |
| cal_rd_adv | output | 1 | Pulse telling the store to step its read pointer |

## Verification
Directed words cover each of the four address codes. The results separate a control load, a calibration pulse and a discarded word. Reads under every read-select value and both byte halves catch a wrong mux leg or swapped halves. Repeated reads after changing the source inputs show that the selection stays in force. A strobe held over several cycles, and a strobe given without chip select, would each misalign the byte phase if counted, so a correct word afterwards tells them apart. A seeded random mix of writes, selection changes and reads against a bench model then covers interleavings that the directed cases miss.

// File: rtl/regif_pkg.sv
package regif_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int ADDR_W   = 2;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int RSEL_LSB = 6;

    typedef enum logic [ADDR_W-1:0] {
        TGT_NONE0 = 2'b00,
        TGT_NONE1 = 2'b01,
        TGT_CAL   = 2'b10,
        TGT_CTRL  = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        RS_RESULT = 2'b00,
        RS_ZERO   = 2'b01,
        RS_CAL    = 2'b10,
        RS_STATUS = 2'b11
    } rsel_e;
endpackage

// File: rtl/regif_strobe_edge.sv
// Turns a level strobe into a single-cycle fire on its first asserted cycle.
// Assumes the level is already synchronous to clk.
module regif_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fire
);
    logic prev_q;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign fire = level & ~prev_q;
endmodule

// File: rtl/regif_wr_assembler.sv
// Pairs two byte writes into one word, low half first.
// Assumes fire is a single-cycle pulse per accepted byte.
module regif_wr_assembler
    import regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    logic              phase_hi_q;
    logic [BYTE_W-1:0] lo_q;

    // Track byte phase and hold the low half until the high half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi_q <= 1'b0;
            lo_q       <= '0;
        end else if (fire) begin
            if (!phase_hi_q) lo_q <= byte_in;
            phase_hi_q <= ~phase_hi_q;
        end
    end

    assign word_vld = fire & phase_hi_q;
    assign word     = {byte_in, lo_q};
endmodule

// File: rtl/regif_rd_mux.sv
// Chooses the read source from the read-select code, then one byte of it.
// Purely combinational; the caller registers the result.
module regif_rd_mux
    import regif_pkg::*;
(
    input  rsel_e             rsel,
    input  logic              hi,
    input  logic [WORD_W-1:0] src_result,
    input  logic [WORD_W-1:0] src_status,
    input  logic [WORD_W-1:0] src_cal,
    output logic [BYTE_W-1:0] byte_out
);
    logic [WORD_W-1:0] word_sel;

    // Source selection by sticky read-select code.
    always_comb begin
        unique case (rsel)
            RS_RESULT: word_sel = src_result;
            RS_CAL:    word_sel = src_cal;
            RS_STATUS: word_sel = src_status;
            default:   word_sel = '0;
        endcase
    end

    assign byte_out = hi ? word_sel[WORD_W-1:BYTE_W] : word_sel[BYTE_W-1:0];
endmodule

// File: rtl/byte_pair_regif.sv
// Host register front end: byte-paired writes with a two-bit target code,
// and sticky read selection held inside the control register.
// Assumes all host inputs are synchronous to clk.
module byte_pair_regif
    import regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic [WORD_W-1:0] conv_data,
    input  logic [WORD_W-1:0] status_in,
    input  logic [WORD_W-1:0] cal_rd_data,
    output logic [PAY_W-1:0]  ctrl,
    output logic              cal_wr_en,
    output logic [PAY_W-1:0]  cal_wr_data,
    output logic              cal_rd_adv
);
    logic              wr_fire, rd_fire, word_vld;
    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] rd_next;
    tgt_e              tgt;
    rsel_e             rsel;
    logic [PAY_W-1:0]  ctrl_q, cal_wr_data_q;
    logic [BYTE_W-1:0] rd_byte_q;
    logic              cal_wr_en_q, cal_rd_adv_q;

    regif_strobe_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .level(cs & wr_stb), .fire(wr_fire));
    regif_strobe_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .level(cs & rd_stb), .fire(rd_fire));

    regif_wr_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .fire(wr_fire), .byte_in(wr_byte),
        .word_vld(word_vld), .word(word)
    );

    assign tgt  = tgt_e'(word[WORD_W-1 -: ADDR_W]);
    assign rsel = rsel_e'(ctrl_q[RSEL_LSB +: 2]);

    regif_rd_mux u_mux (
        .rsel(rsel), .hi(hi_byte), .src_result(conv_data), .src_status(status_in),
        .src_cal(cal_rd_data), .byte_out(rd_next)
    );

    // Control register: loaded only by a completed word addressed to it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (word_vld && tgt == TGT_CTRL) ctrl_q <= word[PAY_W-1:0];
    end

    // Calibration write port: one-cycle pulse with the payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_wr_en_q   <= 1'b0;
            cal_wr_data_q <= '0;
        end else begin
            cal_wr_en_q <= word_vld && tgt == TGT_CAL;
            if (word_vld && tgt == TGT_CAL) cal_wr_data_q <= word[PAY_W-1:0];
        end
    end

    // Read byte capture and calibration pointer advance after a high-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte_q    <= '0;
            cal_rd_adv_q <= 1'b0;
        end else begin
            if (rd_fire) rd_byte_q <= rd_next;
            cal_rd_adv_q <= rd_fire && hi_byte && rsel == RS_CAL;
        end
    end

    assign ctrl        = ctrl_q;
    assign cal_wr_en   = cal_wr_en_q;
    assign cal_wr_data = cal_wr_data_q;
    assign rd_byte     = rd_byte_q;
    assign cal_rd_adv  = cal_rd_adv_q;
endmodule

// File: rtl/byte_pair_regif_checker.sv
// Temporal checks on the register front end, attached by bind.
module byte_pair_regif_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs,
    input logic        wr_stb,
    input logic        rd_stb,
    input logic [7:0]  rd_byte,
    input logic [13:0] ctrl,
    input logic        cal_wr_en,
    input logic        cal_rd_adv
);
    // R3: control only changes after a selected write strobe
    a_r3_ctrl_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(cs && wr_stb));

    // R4: calibration write is a single-cycle pulse
    a_r4_cal_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr_en |=> !cal_wr_en);

    // R8: a calibration write follows a fresh strobe assertion, not a held one
    a_r8_fresh_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr_en |-> ($past(cs && wr_stb) && !$past(cs && wr_stb, 2)));

    // R9: read data moves only after a selected read strobe
    a_r9_rd_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_byte) |-> $past(cs && rd_stb));

    // R10: pointer advance only with calibration read-select
    a_r10_adv_cal_only: assert property (@(posedge clk) disable iff (!rst_n)
        cal_rd_adv |-> ($past(ctrl[7:6]) == 2'b10));
endmodule

bind byte_pair_regif byte_pair_regif_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .rd_byte(rd_byte), .ctrl(ctrl), .cal_wr_en(cal_wr_en), .cal_rd_adv(cal_rd_adv)
);

// File: tb/byte_pair_regif_tb_top.sv
module byte_pair_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, hi_byte = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic [7:0]  rd_byte;
    logic [15:0] conv_data = 16'h0000, status_in = 16'h0000, cal_rd_data = 16'h0000;
    logic [13:0] ctrl, cal_wr_data;
    logic        cal_wr_en, cal_rd_adv;

    int checks = 0, failures = 0;
    logic [13:0] m_ctrl = '0;
    logic        seen_pulse;
    logic [13:0] seen_data;
    logic        seen_adv;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    byte_pair_regif dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .hi_byte(hi_byte), .wr_byte(wr_byte), .rd_byte(rd_byte),
        .conv_data(conv_data), .status_in(status_in), .cal_rd_data(cal_rd_data),
        .ctrl(ctrl), .cal_wr_en(cal_wr_en), .cal_wr_data(cal_wr_data), .cal_rd_adv(cal_rd_adv)
    );

    function automatic logic [7:0] exp_rd(logic [1:0] rs, logic hi);
        logic [15:0] w;
        case (rs)
            2'b00:   w = conv_data;
            2'b10:   w = cal_rd_data;
            2'b11:   w = status_in;
            default: w = 16'h0000;
        endcase
        return hi ? w[15:8] : w[7:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_one(input logic [7:0] b, input int hold, input logic sel);
        @(negedge clk); cs = sel; wr_stb = 1'b1; wr_byte = b;
        for (int i = 1; i < hold; i++) @(negedge clk);
        @(negedge clk); cs = 1'b0; wr_stb = 1'b0;
        seen_pulse = cal_wr_en; seen_data = cal_wr_data;
    endtask

    task automatic wr_word(input logic [15:0] w);
        wr_one(w[7:0], 1, 1'b1);
        wr_one(w[15:8], 1, 1'b1);
    endtask

    task automatic rd_one(input logic hi, output logic [7:0] b);
        @(negedge clk); cs = 1'b1; rd_stb = 1'b1; hi_byte = hi;
        @(negedge clk); cs = 1'b0; rd_stb = 1'b0;
        b = rd_byte; seen_adv = cal_rd_adv;
    endtask

    task automatic check_reads(input string tag);
        logic [7:0] b;
        for (int h = 0; h < 2; h++) begin
            rd_one(h[0], b);
            chk(tag, b, exp_rd(m_ctrl[7:6], h[0]));
            chk("R10 adv", seen_adv, (h == 1) && m_ctrl[7:6] == 2'b10);
        end
    endtask

    task automatic do_write(input logic [15:0] w);
        wr_word(w);
        case (w[15:14])
            2'b11: begin m_ctrl = w[13:0]; chk("R3 ctrl load", ctrl, m_ctrl); chk("R3 no cal", seen_pulse, 0); end
            2'b10: begin chk("R4 cal pulse", seen_pulse, 1); chk("R4 cal data", seen_data, w[13:0]); chk("R4 ctrl kept", ctrl, m_ctrl); end
            default: begin chk("R5 ctrl kept", ctrl, m_ctrl); chk("R5 no cal", seen_pulse, 0); end
        endcase
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 ctrl reset", ctrl, 0);
        chk("R1 rd reset", rd_byte, 0);
        chk("R1 cal reset", cal_wr_en, 0);
        rst_n = 1'b1;
        conv_data = 16'hA55A; status_in = 16'h3CC3; cal_rd_data = 16'h1234;
        check_reads("R6 default result");
        // R2: low byte alone must not update; order matters
        wr_one(8'hC5, 1, 1'b1);
        chk("R2 no update on low", ctrl, 0);
        chk("R2 no pulse on low", seen_pulse, 0);
        wr_one(8'hC0, 1, 1'b1); m_ctrl = 14'h00C5;
        chk("R2 word order", ctrl, m_ctrl);
        check_reads("R6 status sel");
        // R8: held strobe counts once
        wr_one(8'h80, 5, 1'b1);
        chk("R8 held low no update", ctrl, m_ctrl);
        wr_one(8'hC0, 1, 1'b1); m_ctrl = 14'h0080;
        chk("R8 held strobe once", ctrl, m_ctrl);
        status_in = 16'hBEEF; cal_rd_data = 16'h5A01;
        check_reads("R6 cal sel sticky");
        check_reads("R7 cal repeat");
        // R9: strobe without chip select ignored
        wr_one(8'h77, 1, 1'b0);
        do_write(16'hC040);
        chk("R9 no cs ignored", ctrl, 14'h0040);
        check_reads("R6 zero sel");
        do_write(16'h0123);
        do_write(16'h7FFF);
        do_write(16'hABCD);
        do_write(16'hC000);
        // R9: read without chip select keeps byte
        @(negedge clk); rd_stb = 1'b1; hi_byte = 1'b1; conv_data = 16'hFFFF;
        @(negedge clk); rd_stb = 1'b0;
        chk("R9 rd without cs", rd_byte, exp_rd(2'b01, 1'b1));
        check_reads("R7 result halves");
        for (int it = 0; it < 80; it++) begin
            int op = $urandom % 3;
            if (op == 0) do_write(16'($urandom));
            else if (op == 1) do_write({2'b11, 14'($urandom)});
            else begin
                conv_data = 16'($urandom); status_in = 16'($urandom); cal_rd_data = 16'($urandom);
                check_reads("R6 R7 random");
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule